// File: doc/BRIEF.md
# Dual-Order Burst Word Address Generator

This block produces the word address for a four-beat burst. When the load input is high on a rising clock edge, it captures a base address. The two lowest bits of that address become the start value for a wraparound beat counter. On each later edge where the active-low advance input is low, the counter moves one beat. The low address bits then follow one of two orders, picked by a mode input. In linear order the counter counts upward and wraps modulo four. In interleaved order the start value is XORed with the beat count. The upper address bits always come straight from the captured base.

Chip-select qualification of the strobe is done outside the block. `loadEn` must arrive already qualified. The mode input is treated as static while a burst is in progress.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rstN` is low, and after its release before any load, `wordAddr` reads zero.
- R2: When `loadEn` is high on a rising edge, `wordAddr` equals the `baseAddr` sampled at that edge from the next cycle on.
- R3: When `modeIlv` is 0 (linear), after n advances since the load, `wordAddr[1:0]` equals (start + n) mod 4, where start is the loaded `baseAddr[1:0]`.
- R4: When `modeIlv` is 1 (interleaved), after n advances since the load, `wordAddr[1:0]` equals start XOR (n mod 4).
- R5: When `advN` is high and `loadEn` is low on an edge, `wordAddr` is unchanged after that edge.
- R6: After four advances since a load, `wordAddr` is back to the loaded start address.
- R7: A load during a burst replaces the base address and restarts the sequence at beat zero.
- R8: Edges without a load never change `wordAddr[ADDR_W-1:2]`.
- R9: When `loadEn` is high and `advN` is low on the same edge, the load wins: `advN` is ignored and the beat count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Accepted address strobe; captures `baseAddr` |
| baseAddr | input | ADDR_W | Burst start address |
| modeIlv | input | 1 | 1 = interleaved order, 0 = linear order |
| advN | input | 1 | Active-low advance to the next beat |
| wordAddr | output | ADDR_W | Current burst word address |

## Verification
Every result appears exactly one clock after the edge that causes it. Both the captured base and the beat count are registers, and the output is decoded from them combinationally. For each edge it drives, the driver queues one expected address. The monitor pops and compares that address 1 ns after the following rising edge. The reset value is sampled directly, before any edge with stimulus.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic loadStb;
    logic stepStb;
  } burstStb_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic      loadEn,
  input  logic      advN,
  output burstStb_t stb
);
  // Load has priority: an advance on a load edge is dropped (R9)
  always_comb begin
    stb.loadStb = loadEn;
    stb.stepStb = !loadEn && !advN;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStb_t         stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              modeIlv,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseReg;
  logic [BEAT_W-1:0] beatReg;
  logic [BEAT_W-1:0] startLow;
  logic [BEAT_W-1:0] linLow;
  logic [BEAT_W-1:0] ilvLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      beatReg <= '0;
    end else if (stb.loadStb) begin
      baseReg <= baseAddr;
      beatReg <= '0;
    end else if (stb.stepStb) begin
      beatReg <= beatReg + 1'b1;
    end
  end

  assign startLow = baseReg[BEAT_W-1:0];
  assign linLow   = startLow + beatReg;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilvLow[b] = startLow[b] ^ beatReg[b];
  end

  assign wordAddr = {baseReg[ADDR_W-1 -: UPPER_W], (modeIlv ? ilvLow : linLow)};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              modeIlv,
  input  logic              advN,
  output logic [ADDR_W-1:0] wordAddr
);
  burstStb_t stb;

  burst_ctrl u_ctrl (
    .loadEn(loadEn),
    .advN  (advN),
    .stb   (stb)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .baseAddr(baseAddr),
    .modeIlv (modeIlv),
    .wordAddr(wordAddr)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              modeIlv,
  input logic              advN,
  input logic [ADDR_W-1:0] wordAddr
);
  logic              tracked;
  logic [BEAT_W-1:0] homeLow;
  logic [BEAT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tracked <= 1'b0;
      homeLow <= '0;
      stepCnt <= '0;
    end else if (loadEn) begin
      tracked <= 1'b1;
      homeLow <= baseAddr[BEAT_W-1:0];
      stepCnt <= '0;
    end else if (!advN) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> wordAddr == $past(baseAddr)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !advN) |=> wordAddr[BEAT_W-1:0] == $past(baseAddr[BEAT_W-1:0])); // R9

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && advN) |=> ($stable(wordAddr) || !$stable(modeIlv))); // R5

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !advN) |=>
      (wordAddr[BEAT_W-1:0] != $past(wordAddr[BEAT_W-1:0]) || !$stable(modeIlv))); // R3

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> wordAddr[ADDR_W-1:BEAT_W] == $past(wordAddr[ADDR_W-1:BEAT_W])); // R8

  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rstN)
    (tracked && stepCnt == '0) |-> wordAddr[BEAT_W-1:0] == homeLow); // R6
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadEn  (loadEn),
  .baseAddr(baseAddr),
  .modeIlv (modeIlv),
  .advN    (advN),
  .wordAddr(wordAddr)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadEn = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              modeIlv = 1'b0;
  logic              advN = 1'b1;
  logic [ADDR_W-1:0] wordAddr;

  int errors = 0;
  int checks = 0;
  logic [ADDR_W-1:0] expQ[$];
  string             tagQ[$];

  logic [ADDR_W-1:0] mBase = '0;
  logic [1:0]        mBeat = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .baseAddr(baseAddr),
    .modeIlv(modeIlv), .advN(advN), .wordAddr(wordAddr)
  );

  function automatic logic [ADDR_W-1:0] modelAddr(input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
    return {mBase[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wordAddr=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one edge at negedge, push the value due after the next posedge
  task automatic drive(input string tag, input logic ld, input logic [ADDR_W-1:0] b,
                       input logic ilv, input logic aN);
    @(negedge clk);
    loadEn = ld; baseAddr = b; modeIlv = ilv; advN = aN;
    if (ld) begin
      mBase = b; mBeat = '0;
    end else if (!aN) begin
      mBeat = mBeat + 2'd1;
    end
    expQ.push_back(modelAddr(ilv));
    tagQ.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) check(tagQ.pop_front(), wordAddr, expQ.pop_front());
    end
  end

  initial begin : watchdog
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    #12;
    check("R1 in reset", wordAddr, '0);
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 after release", wordAddr, '0);

    // Linear, start 2: 3,0,1 then wrap to 2
    drive("R2 load linear", 1'b1, 17'h1_2346, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) drive("R3 linear step", 1'b0, 17'h0, 1'b0, 1'b0);
    drive("R6 linear wrap", 1'b0, 17'h0, 1'b0, 1'b0);
    drive("R5 hold", 1'b0, 17'h1_FFFF, 1'b0, 1'b1);
    drive("R5 hold again", 1'b0, 17'h0_0000, 1'b0, 1'b1);
    drive("R8 upper kept", 1'b0, 17'h0, 1'b0, 1'b0);

    // Interleaved, start 2: 3,0,1 then wrap, with a suspend midway
    drive("R2 load ilv", 1'b1, 17'h0_ABCE, 1'b1, 1'b1);
    drive("R4 ilv step", 1'b0, 17'h0, 1'b1, 1'b0);
    drive("R5 ilv suspend", 1'b0, 17'h0, 1'b1, 1'b1);
    drive("R4 ilv step", 1'b0, 17'h0, 1'b1, 1'b0);
    drive("R4 ilv step", 1'b0, 17'h0, 1'b1, 1'b0);
    drive("R6 ilv wrap", 1'b0, 17'h0, 1'b1, 1'b0);

    // Interleaved, start 1: 0,3,2
    drive("R2 load ilv s1", 1'b1, 17'h1_0001, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) drive("R4 ilv s1 step", 1'b0, 17'h0, 1'b1, 1'b0);

    // Load wins over advance, then reload mid-burst
    drive("R9 load with adv", 1'b1, 17'h0_5553, 1'b0, 1'b0);
    drive("R3 linear from 3", 1'b0, 17'h0, 1'b0, 1'b0);
    drive("R7 reload mid burst", 1'b1, 17'h1_7771, 1'b0, 1'b1);
    drive("R7 restart step", 1'b0, 17'h0, 1'b0, 1'b0);
    drive("R7 restart step", 1'b0, 17'h0, 1'b0, 1'b0);

    @(negedge clk); loadEn = 1'b0; advN = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule